// File: doc/BRIEF.md
# Cache cluster power-up sequencer

This block brings a shared second-level cache cluster from an unpowered state to a running state. After an accepted start pulse it walks a fixed, ordered list of writes to three control outputs: the cluster power-control word, a debug-reset override word and a two-bit clock-branch control. Between some steps it waits a fixed number of microseconds. The number of clock cycles per microsecond is a parameter. The last step turns on the external supply request and passes the cluster clock to hardware control.

A head-switch status input reports whether the cluster already has power. The block samples it only in the cycle in which it accepts a start. If the status is high at that point, the block leaves every output as it is and answers with done at once. While a sequence is running, further start pulses and changes on the status input have no effect.

Top module: `l2_pwrup_seq`

## Requirements
- R1: A synchronous reset clears the power-control word, the override word and the clock-branch bits to zero and drives busy and done low, including when it arrives in the middle of a sequence.
- R2: Suppose start is accepted while idle and the status input is high. Then done is high in the next cycle, busy stays low, and none of the three control outputs changes.
- R3: On the edge that accepts start with the status low, the power-control word becomes 0x0010D700 and the override word becomes 0x00400000. That power-control value sets head-switch clamp bit 8, enable bit 9, head-switch reset bit 10, system reset bit 12, array clamps bits 14 and 15, and a count of 16 in bits 27:16. The override value is bit 22. Busy rises at the same edge. These values hold for 2 us.
- R4: After that wait, both array clamps (bits 15 and 14) clear together, giving 0x00101700. One cycle later, head-switch bits 0 and 1 both set, giving 0x00101703. A 2 us wait follows.
- R5: Clock-branch enable (bit 0 of the clock-branch output) then sets. One cycle later the head-switch clamp, bit 8, clears, giving 0x00101603. A 2 us wait follows.
- R6: In one cycle the override word returns to zero and both resets, bits 10 and 12, clear, giving 0x00100203. A 54 us wait follows.
- R7: In the final step, supply-on bit 28 sets (0x10100203) and hardware control (bit 1) of the clock branch sets. In the same edge busy falls and done rises. Done lasts exactly one cycle. With CYCLES_PER_US = 4, the steps fall 0, 8, 9, 17, 18, 26 and 242 cycles after the accepting edge.
- R8: While busy, a start pulse or a high status input has no effect on the sequence or its timing.
- R9: When idle and start is low, all control outputs keep their values. After completion they hold the final step's values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to power up the cluster |
| hs_sts | input | 1 | Cluster head switch already on |
| pwr_ctl | output | 32 | Cluster power-control word |
| ovr_word | output | 32 | Override word, bit 22 holds debug reset |
| clkbr | output | 2 | Clock branch: bit 0 enable, bit 1 hardware control |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to create is a start pulse that arrives together with a high status in the middle of a wait. If the block took that pulse, it would either restart or signal done early. The stimulus injects exactly that pulse three cycles into the first wait. It then checks every later step at its exact cycle offset, both one cycle before the change and at the change, so any shift in timing is seen. A reset partway through a run and a skip run on a status of high cover the other two ways of entering idle.

// File: rtl/l2_pwrup_seq.sv
module l2_pwrup_seq #(
  parameter int CYCLES_PER_US = 4,
  parameter int SHORT_US      = 2,
  parameter int LONG_US       = 54,
  parameter int HS_COUNT      = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        hs_sts,
  output logic [31:0] pwr_ctl,
  output logic [31:0] ovr_word,
  output logic [1:0]  clkbr,
  output logic        busy,
  output logic        done
);
  localparam int SHORT_CYC = SHORT_US * CYCLES_PER_US;
  localparam int LONG_CYC  = LONG_US * CYCLES_PER_US;
  localparam int CW        = $clog2(LONG_CYC + 1);

  localparam logic [31:0] B_ARR_HS  = 32'h1 << 0;
  localparam logic [31:0] B_SCU_HS  = 32'h1 << 1;
  localparam logic [31:0] B_CLAMP   = 32'h1 << 8;
  localparam logic [31:0] B_HS_EN   = 32'h1 << 9;
  localparam logic [31:0] B_HS_RST  = 32'h1 << 10;
  localparam logic [31:0] B_SYS_RST = 32'h1 << 12;
  localparam logic [31:0] B_SCU_CLP = 32'h1 << 14;
  localparam logic [31:0] B_ARR_CLP = 32'h1 << 15;
  localparam logic [31:0] B_SUPPLY  = 32'h1 << 28;
  localparam logic [31:0] CNT_FLD   = (32'(HS_COUNT) & 32'hFFF) << 16;
  localparam logic [31:0] B_DBG_OVR = 32'h1 << 22;

  localparam logic [31:0] FIRST_WORD = B_CLAMP | B_HS_EN | B_HS_RST | B_SYS_RST |
                                       B_SCU_CLP | B_ARR_CLP | CNT_FLD;

  localparam logic [CW-1:0] SHORT_LD = CW'(SHORT_CYC - 1);
  localparam logic [CW-1:0] LONG_LD  = CW'(LONG_CYC - 1);

  typedef enum logic [2:0] {
    IDLE, WAIT_A, OPEN_HS, WAIT_B, DROP_CLAMP, WAIT_C, WAIT_D
  } st_t;

  st_t          st;
  logic [CW-1:0] cnt;
  wire          expired = (cnt == '0);

  assign busy = (st != IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= IDLE;
      cnt      <= '0;
      pwr_ctl  <= '0;
      ovr_word <= '0;
      clkbr    <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        IDLE: if (start) begin
          if (hs_sts) begin
            done <= 1'b1;
          end else begin
            pwr_ctl  <= FIRST_WORD;
            ovr_word <= B_DBG_OVR;
            cnt      <= SHORT_LD;
            st       <= WAIT_A;
          end
        end
        WAIT_A: if (expired) begin
          pwr_ctl <= pwr_ctl & ~(B_SCU_CLP | B_ARR_CLP);
          st      <= OPEN_HS;
        end else cnt <= cnt - 1'b1;
        OPEN_HS: begin
          pwr_ctl <= pwr_ctl | B_ARR_HS | B_SCU_HS;
          cnt     <= SHORT_LD;
          st      <= WAIT_B;
        end
        WAIT_B: if (expired) begin
          clkbr[0] <= 1'b1;
          st       <= DROP_CLAMP;
        end else cnt <= cnt - 1'b1;
        DROP_CLAMP: begin
          pwr_ctl <= pwr_ctl & ~B_CLAMP;
          cnt     <= SHORT_LD;
          st      <= WAIT_C;
        end
        WAIT_C: if (expired) begin
          ovr_word <= ovr_word & ~B_DBG_OVR;
          pwr_ctl  <= pwr_ctl & ~(B_HS_RST | B_SYS_RST);
          cnt      <= LONG_LD;
          st       <= WAIT_D;
        end else cnt <= cnt - 1'b1;
        WAIT_D: if (expired) begin
          pwr_ctl  <= pwr_ctl | B_SUPPLY;
          clkbr[1] <= 1'b1;
          done     <= 1'b1;
          st       <= IDLE;
        end else cnt <= cnt - 1'b1;
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/l2_pwrup_seq_chk.sv
module l2_pwrup_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic        hs_sts,
  input logic [31:0] pwr_ctl,
  input logic [31:0] ovr_word,
  input logic [1:0]  clkbr,
  input logic        busy,
  input logic        done
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (pwr_ctl == '0 && ovr_word == '0 && clkbr == '0 && !busy && !done));

  // R2
  skip_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && hs_sts) |=> (done && !busy && $stable(pwr_ctl) &&
                                    $stable(ovr_word) && $stable(clkbr)));

  // R4
  hs_after_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    (pwr_ctl[0] || pwr_ctl[1]) |-> (!pwr_ctl[14] && !pwr_ctl[15]));

  // R5
  clamp_after_clk_chk: assert property (@(posedge clk) disable iff (rst)
    (pwr_ctl[9] && !pwr_ctl[8]) |-> clkbr[0]);

  // R6
  supply_after_release_chk: assert property (@(posedge clk) disable iff (rst)
    pwr_ctl[28] |-> (ovr_word == '0 && !pwr_ctl[10] && !pwr_ctl[12]));

  // R7
  done_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(pwr_ctl) && $stable(ovr_word) && $stable(clkbr)));
endmodule

bind l2_pwrup_seq l2_pwrup_seq_chk chk_i (
  .clk(clk), .rst(rst), .start(start), .hs_sts(hs_sts),
  .pwr_ctl(pwr_ctl), .ovr_word(ovr_word), .clkbr(clkbr),
  .busy(busy), .done(done)
);

// File: tb/l2_pwrup_seq_tb_top.sv
`timescale 1ns/1ps
module l2_pwrup_seq_tb_top;
  localparam int C = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic hs_sts = 1'b0;
  logic [31:0] pwr_ctl, ovr_word;
  logic [1:0]  clkbr;
  logic        busy, done;

  always #2.5 clk = ~clk;

  l2_pwrup_seq #(.CYCLES_PER_US(C)) dut_i (
    .clk(clk), .rst(rst), .start(start), .hs_sts(hs_sts),
    .pwr_ctl(pwr_ctl), .ovr_word(ovr_word), .clkbr(clkbr),
    .busy(busy), .done(done)
  );

  localparam int          OFF  [0:6] = '{0, 2*C, 2*C+1, 4*C+1, 4*C+2, 6*C+2, 60*C+2};
  localparam logic [31:0] EPWR [0:6] = '{32'h0010D700, 32'h00101700, 32'h00101703,
                                         32'h00101703, 32'h00101603, 32'h00100203,
                                         32'h10100203};
  localparam logic [31:0] EOVR [0:6] = '{32'h00400000, 32'h00400000, 32'h00400000,
                                         32'h00400000, 32'h00400000, 32'h0, 32'h0};
  localparam logic [1:0]  ECLK [0:6] = '{2'b00, 2'b00, 2'b00, 2'b01, 2'b01, 2'b01, 2'b11};
  localparam string       REQ  [0:6] = '{"R3", "R4", "R4", "R5", "R5", "R6", "R7"};

  int checks = 0;
  int errors = 0;
  int cur = 0;
  bit inject = 1'b0;

  task automatic chk(string req, logic [67:0] act, logic [67:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", req, cur, act, exp);
    end
  endtask

  function automatic logic [67:0] obs();
    return {pwr_ctl, ovr_word, clkbr, busy, done};
  endfunction

  task automatic tick();
    @(posedge clk);
    cur++;
    @(negedge clk);
    if (inject && cur == 3) begin
      start  = 1'b1;
      hs_sts = 1'b1;
    end else if (inject && cur == 4) begin
      start  = 1'b0;
      hs_sts = 1'b0;
    end else if (inject && cur == 5) begin
      chk("R8", obs(), {EPWR[0], EOVR[0], ECLK[0], 1'b1, 1'b0});
    end
  endtask

  task automatic launch(bit sts);
    @(negedge clk);
    start  = 1'b1;
    hs_sts = sts;
    @(posedge clk);
    cur = 0;
    @(negedge clk);
    start  = 1'b0;
    hs_sts = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", obs(), 68'h0);
    rst = 1'b0;

    launch(1'b0);
    inject = 1'b1;
    chk(REQ[0], obs(), {EPWR[0], EOVR[0], ECLK[0], 1'b1, 1'b0});
    for (int i = 1; i < 7; i++) begin
      while (cur < OFF[i] - 1) tick();
      chk(REQ[i-1], obs(), {EPWR[i-1], EOVR[i-1], ECLK[i-1], 1'b1, 1'b0});
      tick();
      chk(REQ[i], obs(), {EPWR[i], EOVR[i], ECLK[i], i != 6, i == 6});
    end
    inject = 1'b0;
    tick();
    // R7: done lasts one cycle
    chk("R7", obs(), {EPWR[6], EOVR[6], ECLK[6], 1'b0, 1'b0});
    repeat (5) tick();
    // R9: final values held while idle
    chk("R9", obs(), {EPWR[6], EOVR[6], ECLK[6], 1'b0, 1'b0});

    // R1: reset in the middle of a run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    launch(1'b0);
    while (cur < 20) tick();
    chk("R5", obs(), {EPWR[4], EOVR[4], ECLK[4], 1'b1, 1'b0});
    rst = 1'b1;
    tick();
    chk("R1", obs(), 68'h0);
    rst = 1'b0;

    // R2: status already high skips the sequence
    launch(1'b1);
    chk("R2", obs(), {32'h0, 32'h0, 2'b00, 1'b0, 1'b1});
    tick();
    chk("R2", obs(), 68'h0);
    repeat (3) tick();
    // R9: idle with start low keeps outputs
    chk("R9", obs(), 68'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule